// File: doc/BRIEF.md
# Truncated Low-Half Array Multiplier

This block multiplies two unsigned N-bit operands and returns only the low N bits of the product. It has no clock and no state. Output column i is built from the partial products whose indices sum to i. Before any addition, each mirrored pair of partial products (a[j]&b[k] together with a[k]&b[j]) is merged in one four-input cell. That cell gives a sum bit of weight i and a carry bit of weight i+1.

Each column starts its list of addends with the carries from the column below it. The column's own pair-cell sums follow in the order the pairs are formed, working inward from the outermost pair. When i is even, the lone square term a[i/2]&b[i/2] comes last. The list is reduced by half adders in rounds. In each round the first element is paired with the last, the second with the second-to-last, and so on. An unpaired middle element passes unchanged to the next round. All carries go up one column. Carries leaving the top column have weight 2^N and are dropped.

The block fits where a wrapped, fixed-width product is wanted, such as index scaling or hashing. Placing a register stage around it is left to the instantiating logic.

Top module: `trunc_pair_mul`

## Requirements
- R1: For every operand pair, p_o equals (a_i * b_i) mod 2^N, with all three values read as unsigned binary.
- R2: Bit 0 of p_o equals a_i[0] AND b_i[0].
- R3: When either operand is zero, p_o is zero.
- R4: When one operand equals 1, p_o equals the other operand.
- R5: When one operand is 2^s (only bit s set, 0 <= s < N), p_o equals the other operand shifted left by s, with bits at position N and above dropped.
- R6: With both operands all-ones, p_o equals 1. With one operand all-ones, p_o equals the two's-complement negation of the other operand modulo 2^N.
- R7: Product bits of weight 2^N and above never appear in p_o. For example, 2^(N-1) times 2 gives zero.
- R8: Swapping the two operands leaves p_o unchanged.
- R9: p_o follows any change of a_i or b_i without any clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| p_o | output | N | Low N bits of a_i * b_i |

## Verification
The checker takes the operands to be fully known two-state values. While any input or output bit is unknown it skips evaluation. The checker has no clock, so its judgements also assume that it looks at p_o only after the combinational cone has settled. The bench follows both assumptions. It drives a_i and b_i with defined values from the start, including during reset. Each operand change is made well away from the sampling edge. Both the 4-bit exhaustive sweep and the 8-bit directed and random patterns stay inside the unsigned operand range.

// File: rtl/trunc_pair_mul_pkg.sv
package trunc_pair_mul_pkg;

  // Mirrored index pairs (j,k) with j<k and j+k == col.
  function automatic int f_pairs(input int col);
    return (col + 1) / 2;
  endfunction

  // Even columns also carry the square term a[col/2]&b[col/2].
  function automatic int f_single(input int col);
    return ((col % 2) == 0) ? 1 : 0;
  endfunction

  // Number of carries arriving at column col from column col-1.
  function automatic int f_cin(input int col);
    int c;
    c = 0;
    for (int k = 0; k < col; k++) begin
      c = f_pairs(k) + (c + f_pairs(k) + f_single(k)) - 1;
    end
    return c;
  endfunction

  function automatic int f_addends(input int col);
    return f_cin(col) + f_pairs(col) + f_single(col);
  endfunction

  // Carries leaving column col: one per pair cell plus one per half adder.
  function automatic int f_cout(input int col);
    return f_pairs(col) + f_addends(col) - 1;
  endfunction

  // Offset of column col's outgoing carries in the flat carry bus.
  function automatic int f_coff(input int col);
    int s;
    s = 0;
    for (int k = 0; k < col; k++) s = s + f_cout(k);
    return s;
  endfunction

  // Element count at the start of reduction round r for m addends.
  function automatic int f_lvl_cnt(input int m, input int r);
    int n;
    n = m;
    for (int k = 0; k < r; k++) n = (n + 1) / 2;
    return n;
  endfunction

  function automatic int f_rounds(input int m);
    int n;
    int r;
    n = m;
    r = 0;
    for (int k = 0; k < 32; k++) begin
      if (n > 1) begin
        n = (n + 1) / 2;
        r = r + 1;
      end
    end
    return r;
  endfunction

  function automatic int f_lvl_off(input int m, input int r);
    int s;
    s = 0;
    for (int k = 0; k < r; k++) s = s + f_lvl_cnt(m, k);
    return s;
  endfunction

  // Index of the first half-adder carry produced in round r.
  function automatic int f_ha_base(input int m, input int r);
    int s;
    s = 0;
    for (int k = 0; k < r; k++) s = s + f_lvl_cnt(m, k) / 2;
    return s;
  endfunction

endpackage

// File: rtl/trunc_pair_mul_cell.sv
// Four-input mirrored partial-product cell.
// Sum  = (x&y) XOR (z&w), built from NAND terms gated by NOT(x&y&z&w).
// Carry = x&y&z&w; only present when KEEP is set.
module trunc_pair_mul_cell #(
  parameter bit KEEP = 1'b1,
  localparam int OW  = KEEP ? 2 : 1
) (
  input  logic          x_i,
  input  logic          y_i,
  input  logic          z_i,
  input  logic          w_i,
  output logic [OW-1:0] res_o
);
  logic nand_xy;
  logic nand_zw;
  logic any_prod;
  logic all_four;

  assign nand_xy  = ~(x_i & y_i);
  assign nand_zw  = ~(z_i & w_i);
  assign any_prod = ~(nand_xy & nand_zw);
  assign all_four = x_i & y_i & z_i & w_i;
  assign res_o[0] = any_prod & ~all_four;

  if (KEEP) begin : g_carry
    assign res_o[OW-1] = all_four;
  end
endmodule

// File: rtl/trunc_pair_mul_half_add.sv
module trunc_pair_mul_half_add (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

// File: rtl/trunc_pair_mul_reduce.sv
// Reduces M same-weight addends to one bit by rounds of outer-inner pairing.
// res_o[0] is the column bit; res_o[M-1:1] are the M-1 half-adder carries.
module trunc_pair_mul_reduce
  import trunc_pair_mul_pkg::*;
#(
  parameter int M    = 1,
  parameter bit KEEP = 1'b1,
  localparam int RW  = KEEP ? M : 1
) (
  input  logic [M-1:0]  add_i,
  output logic [RW-1:0] res_o
);
  localparam int ROUNDS = f_rounds(M);
  localparam int TOT    = f_lvl_off(M, ROUNDS + 1);

  logic [TOT-1:0] lvl;

  assign lvl[M-1:0] = add_i;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    localparam int CNT  = f_lvl_cnt(M, r);
    localparam int HALF = CNT / 2;
    localparam int SRC  = f_lvl_off(M, r);
    localparam int DST  = f_lvl_off(M, r + 1);
    localparam int CB   = f_ha_base(M, r);

    for (genvar j = 0; j < HALF; j++) begin : g_pair
      if (KEEP) begin : g_ha
        trunc_pair_mul_half_add ha_i (
          .x_i (lvl[SRC + j]),
          .y_i (lvl[SRC + CNT - 1 - j]),
          .s_o (lvl[DST + j]),
          .c_o (res_o[1 + CB + j])
        );
      end else begin : g_xor
        assign lvl[DST + j] = lvl[SRC + j] ^ lvl[SRC + CNT - 1 - j];
      end
    end

    if ((CNT % 2) == 1) begin : g_mid
      assign lvl[DST + HALF] = lvl[SRC + HALF];
    end
  end

  assign res_o[0] = lvl[TOT-1];
endmodule

// File: rtl/trunc_pair_mul.sv
// Truncated unsigned multiplier: p_o = (a_i * b_i) mod 2^N. Requires N >= 3.
module trunc_pair_mul
  import trunc_pair_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] p_o
);
  // Carries leaving columns 0..N-2; the top column's carries are never built.
  localparam int CTOT = f_coff(N - 1);

  logic [CTOT-1:0] cbus;

  for (genvar i = 0; i < N; i++) begin : g_col
    localparam int CIN     = f_cin(i);
    localparam int NP      = f_pairs(i);
    localparam int SG      = f_single(i);
    localparam int M       = f_addends(i);
    localparam bit KEEP    = (i < N - 1);
    localparam int RW      = KEEP ? M : 1;
    localparam int OUT_OFF = f_coff(i);
    localparam int IN_OFF  = (i > 0) ? f_coff(i - 1) : 0;

    logic [M-1:0]  add_w;
    logic [RW-1:0] red_w;

    // Incoming carries lead the addend list.
    if (CIN > 0) begin : g_cin
      assign add_w[CIN-1:0] = cbus[IN_OFF +: CIN];
    end

    for (genvar p = 0; p < NP; p++) begin : g_cell
      localparam int J = p;
      localparam int K = i - p;
      logic [(KEEP ? 2 : 1)-1:0] cell_w;

      trunc_pair_mul_cell #(.KEEP(KEEP)) cell_i (
        .x_i   (a_i[J]),
        .y_i   (b_i[K]),
        .z_i   (a_i[K]),
        .w_i   (b_i[J]),
        .res_o (cell_w)
      );

      assign add_w[CIN + p] = cell_w[0];
      if (KEEP) begin : g_cc
        assign cbus[OUT_OFF + p] = cell_w[1];
      end
    end

    if (SG == 1) begin : g_sq
      assign add_w[M-1] = a_i[i/2] & b_i[i/2];
    end

    trunc_pair_mul_reduce #(.M(M), .KEEP(KEEP)) red_i (
      .add_i (add_w),
      .res_o (red_w)
    );

    assign p_o[i] = red_w[0];

    if (KEEP && (M > 1)) begin : g_hc
      assign cbus[OUT_OFF + NP +: M - 1] = red_w[M-1:1];
    end
  end
endmodule

// File: rtl/trunc_pair_mul_chk.sv
module trunc_pair_mul_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N-1:0] p_o
);
  logic [2*N-1:0] full;
  logic [N-1:0]   sh_a;
  logic [N-1:0]   neg_b;

  always_comb begin
    full  = {{N{1'b0}}, a_i} * {{N{1'b0}}, b_i};
    sh_a  = '0;
    for (int s = 0; s < N; s++) begin
      if (b_i[s]) sh_a = a_i << s;
    end
    neg_b = (~b_i) + 1'b1;

    if (!$isunknown({a_i, b_i, p_o})) begin
      p_low_product_r1: assert (p_o == full[N-1:0])
        else $error("R1 product mismatch");
      p_bit0_and_r2: assert (p_o[0] == (a_i[0] & b_i[0]))
        else $error("R2 bit 0 mismatch");
      if ((a_i == '0) || (b_i == '0)) begin
        p_zero_operand_r3: assert (p_o == '0)
          else $error("R3 zero operand gave nonzero");
      end
      if (b_i == {{(N-1){1'b0}}, 1'b1}) begin
        p_unit_operand_r4: assert (p_o == a_i)
          else $error("R4 unit operand mismatch");
      end
      if ($onehot(b_i)) begin
        p_pow2_shift_r5: assert (p_o == sh_a)
          else $error("R5 shift mismatch");
      end
      if (a_i == '1) begin
        p_ones_negate_r6: assert (p_o == neg_b)
          else $error("R6 all-ones mismatch");
      end
    end
  end
endmodule

bind trunc_pair_mul trunc_pair_mul_chk #(.N(N)) chk_i (
  .a_i (a_i),
  .b_i (b_i),
  .p_o (p_o)
);

// File: tb/trunc_pair_mul_tb_top.sv
module trunc_pair_mul_tb_top;
  logic clk;
  logic rst_n;

  logic [7:0] a8, b8;
  logic [7:0] p8;
  logic [3:0] a4, b4;
  logic [3:0] p4;

  int checks;
  int errors;

  // Scoreboard queues, one entry per driven pattern.
  bit         q_w4  [$];
  logic [7:0] q_a   [$];
  logic [7:0] q_b   [$];
  logic [7:0] q_exp [$];
  string      q_req [$];

  trunc_pair_mul #(.N(8)) dut_i  (.a_i(a8), .b_i(b8), .p_o(p8));
  trunc_pair_mul #(.N(4)) dut4_i (.a_i(a4), .b_i(b4), .p_o(p4));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic direct_check(input logic [7:0] got, input logic [7:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic send8(input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] exp, input string req);
    @(posedge clk);
    #1;
    a8 = a;
    b8 = b;
    q_w4.push_back(1'b0);
    q_a.push_back(a);
    q_b.push_back(b);
    q_exp.push_back(exp);
    q_req.push_back(req);
  endtask

  task automatic send4(input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] exp, input string req);
    @(posedge clk);
    #1;
    a4 = a;
    b4 = b;
    q_w4.push_back(1'b1);
    q_a.push_back({4'h0, a});
    q_b.push_back({4'h0, b});
    q_exp.push_back({4'h0, exp});
    q_req.push_back(req);
  endtask

  // Monitor: compares one expected item per falling edge.
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      bit         w4;
      logic [7:0] ea, eb, ex, got;
      string      rq;
      w4 = q_w4.pop_front();
      ea = q_a.pop_front();
      eb = q_b.pop_front();
      ex = q_exp.pop_front();
      rq = q_req.pop_front();
      got = w4 ? {4'h0, p4} : p8;
      checks++;
      if (got !== ex) begin
        errors++;
        $display("FAIL %s: a=%0h b=%0h got %0h expected %0h", rq, ea, eb, got, ex);
      end
    end
  end

  function automatic logic [7:0] mul8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] f;
    f = {8'h00, a} * {8'h00, b};
    return f[7:0];
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    a8 = 8'h00;
    b8 = 8'h00;
    a4 = 4'h0;
    b4 = 4'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    direct_check(p8, 8'h00, "R3 reset-time zero operands");
    direct_check({4'h0, p4}, 8'h00, "R3 reset-time zero operands n4");
    rst_n = 1'b1;

    // R9: output follows inputs between clock edges.
    @(negedge clk);
    #1;
    a8 = 8'd13;
    b8 = 8'd11;
    #1;
    direct_check(p8, 8'd143, "R9 comb follow 13*11");
    b8 = 8'd0;
    #1;
    direct_check(p8, 8'd0, "R9 comb follow to zero");

    // R3 zero operands
    send8(8'h00, 8'hA7, 8'h00, "R3");
    send8(8'h5C, 8'h00, 8'h00, "R3");
    // R4 unit operands
    send8(8'h01, 8'hC3, 8'hC3, "R4");
    send8(8'h9E, 8'h01, 8'h9E, "R4");
    // R5 power-of-two operands
    for (int s = 0; s < 8; s++) begin
      send8(8'hB5, 8'h01 << s, 8'hB5 << s, "R5");
    end
    // R6 all-ones
    send8(8'hFF, 8'hFF, 8'h01, "R6");
    send8(8'hFF, 8'h03, 8'hFD, "R6");
    send8(8'h2A, 8'hFF, 8'hD6, "R6");
    // R7 dropped overflow
    send8(8'h80, 8'h02, 8'h00, "R7");
    send8(8'h10, 8'h10, 8'h00, "R7");
    send8(8'hC0, 8'h0C, 8'h00, "R7");
    // R2 bit 0 parity combinations
    send8(8'h03, 8'h05, 8'h0F, "R2");
    send8(8'h02, 8'h07, 8'h0E, "R2");
    send8(8'h07, 8'h02, 8'h0E, "R2");
    // R8 commutativity
    send8(8'h3B, 8'hD4, mul8(8'h3B, 8'hD4), "R8");
    send8(8'hD4, 8'h3B, mul8(8'h3B, 8'hD4), "R8");
    send8(8'h77, 8'h99, mul8(8'h99, 8'h77), "R8");
    send8(8'h99, 8'h77, mul8(8'h99, 8'h77), "R8");
    // R1 random 8-bit
    for (int n = 0; n < 1000; n++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      send8(ra, rb, mul8(ra, rb), "R1");
    end
    // R1 exhaustive 4-bit
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        logic [7:0] e;
        e = 8'(x * y);
        send4(4'(x), 4'(y), e[3:0], "R1");
      end
    end

    wait (q_exp.size() == 0);
    @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule